// File: doc/BRIEF.md
# Supply Monitor Filter and Event Logic

This block is the digital back end of one supply-voltage monitor channel. An analog comparator reports, asynchronously, whether the supply sits above (1) or below (0) a threshold. The block brings that level into the system clock domain through two flops. It can pass the level through a sampling noise filter whose sample rate is a divided low-speed oscillator tick. The result drives a live level flag and a sticky crossing flag.

A crossing in the selected direction raises the sticky flag. Depending on configuration, the crossing then either pulses a maskable or a non-maskable interrupt request, or holds a reset output. Two policies set when that reset is released. The low-speed oscillator arrives as `lso_tick`, a one-cycle pulse in the system clock domain once per oscillator period. Configuration is given by plain level inputs plus a clear strobe for the sticky flag.

Top module: `supply_mon_evt`

## Requirements
- R1: `cmp_in` passes through a two-flop synchroniser. With the filter off (`cfg_filt_en`=0), `mon_flag` takes a new `cmp_in` level three clock edges after it is driven.
- R2: With `cfg_filt_en`=1, a new level is accepted only when two consecutive samples agree. A pulse shorter than one sample period therefore leaves `mon_flag` and `det_flag` unchanged.
- R3: Samples are taken on every n-th `lso_tick`, where `cfg_div` 0,1,2,3 selects n = 1,2,4,8.
- R4: `mon_flag` is the live (filtered) level, 1 = above threshold. It resets to 1.
- R5: `det_flag` is set by a selected crossing and stays set until `det_clr` is 1. When a clear and a crossing fall in the same cycle, the flag ends up set.
- R6: `cfg_dir` selects the crossings that count: 00 falling, 01 rising, 10 or 11 both.
- R7: With `cfg_rst_mode`=0, each counted crossing gives a one-cycle pulse in the same cycle that `det_flag` sets. The pulse is on `irq_mask` when `cfg_nmi`=0 and on `irq_nmi` when `cfg_nmi`=1. The two outputs are never high together.
- R8: With `cfg_rst_mode`=1, no interrupt pulse is issued. With `cfg_rel_mode`=0, `rst_out` is high whenever `mon_flag` is 0.
- R9: With `cfg_rel_mode`=0, `rst_out` falls once `cfg_rel_cnt` `lso_tick`s have been counted with the level above the threshold. Any return below the threshold restarts the count.
- R10: With `cfg_rel_mode`=1, a falling crossing raises `rst_out`. It falls after `cfg_rel_cnt` `lso_tick`s whatever the level, and stays low until the next falling crossing.
- R11: With `cfg_en`=0, no crossing sets `det_flag`, pulses an interrupt or raises `rst_out`, while `mon_flag` keeps tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_in | input | 1 | Asynchronous comparator level, 1 = above |
| lso_tick | input | 1 | One-cycle pulse per low-speed oscillator period |
| cfg_en | input | 1 | Channel enable |
| cfg_filt_en | input | 1 | Noise filter enable |
| cfg_div | input | 2 | Sample divider select (n = 1,2,4,8) |
| cfg_dir | input | 2 | Crossing direction select |
| cfg_rst_mode | input | 1 | 0 interrupt response, 1 reset response |
| cfg_nmi | input | 1 | Interrupt kind: 0 maskable, 1 non-maskable |
| cfg_rel_mode | input | 1 | Reset release: 0 after recovery, 1 after detection |
| cfg_rel_cnt | input | DLY_W | Release delay in lso_tick periods |
| det_clr | input | 1 | Write-1 clear of det_flag |
| mon_flag | output | 1 | Live level flag |
| det_flag | output | 1 | Sticky crossing flag |
| irq_mask | output | 1 | Maskable interrupt pulse |
| irq_nmi | output | 1 | Non-maskable interrupt pulse |
| rst_out | output | 1 | Held reset request |

## Verification
Single falls and rises are driven under each direction code. Each must produce exactly the queued interrupt kind or nothing, which separates the falling, rising and both-direction decodes and the maskable and non-maskable routing. A short low glitch is applied with the filter off and again with it on: the first must register and the second must not. Slow level changes with the divider at n=1 and n=8 are sampled inside and after the two-sample window, which tells the divider settings apart. In reset mode, recoveries interrupted by a brief drop and long low periods under the after-detection policy show which of the two release policies is active.

// File: rtl/supply_mon_evt.sv
module supply_mon_evt #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_in,
  input  logic             lso_tick,
  input  logic             cfg_en,
  input  logic             cfg_filt_en,
  input  logic [1:0]       cfg_div,
  input  logic [1:0]       cfg_dir,
  input  logic             cfg_rst_mode,
  input  logic             cfg_nmi,
  input  logic             cfg_rel_mode,
  input  logic [DLY_W-1:0] cfg_rel_cnt,
  input  logic             det_clr,
  output logic             mon_flag,
  output logic             det_flag,
  output logic             irq_mask,
  output logic             irq_nmi,
  output logic             rst_out
);

  typedef enum logic {ST_IDLE, ST_HOLD} rst_st_t;

  logic s1, s2;
  logic [2:0] div_cnt, div_max;
  logic sample_en;
  logic samp_q, filt_q;
  logic level, lvl_q;
  logic rise, fall, evt;
  logic det_q, irqm_q, irqn_q;
  rst_st_t st;
  logic [DLY_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= cmp_in;
      s2 <= s1;
    end
  end

  always_comb begin
    case (cfg_div)
      2'd0:    div_max = 3'd0;
      2'd1:    div_max = 3'd1;
      2'd2:    div_max = 3'd3;
      default: div_max = 3'd7;
    endcase
  end

  assign sample_en = lso_tick && (div_cnt >= div_max);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      samp_q  <= 1'b1;
      filt_q  <= 1'b1;
    end else begin
      if (lso_tick) div_cnt <= (div_cnt >= div_max) ? 3'd0 : div_cnt + 3'd1;
      if (sample_en) begin
        samp_q <= s2;
        if (s2 == samp_q) filt_q <= s2;
      end
    end
  end

  assign level = cfg_filt_en ? filt_q : s2;
  assign rise  = level && !lvl_q;
  assign fall  = !level && lvl_q;
  assign evt   = cfg_en && (cfg_dir[1] ? (rise || fall) : (cfg_dir[0] ? rise : fall));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b1;
      det_q  <= 1'b0;
      irqm_q <= 1'b0;
      irqn_q <= 1'b0;
    end else begin
      lvl_q  <= level;
      det_q  <= evt ? 1'b1 : (det_clr ? 1'b0 : det_q);
      irqm_q <= evt && !cfg_rst_mode && !cfg_nmi;
      irqn_q <= evt && !cfg_rst_mode && cfg_nmi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else if (!cfg_en || !cfg_rst_mode) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          cnt <= '0;
          if (cfg_rel_mode ? fall : !level) st <= ST_HOLD;
        end
        default: begin
          if (!cfg_rel_mode && !level) cnt <= '0;
          else if (cnt >= cfg_rel_cnt) st <= ST_IDLE;
          else if (lso_tick) cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  assign mon_flag = lvl_q;
  assign det_flag = det_q;
  assign irq_mask = irqm_q;
  assign irq_nmi  = irqn_q;
  assign rst_out  = (st == ST_HOLD);

  p_irq_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_mask && irq_nmi));
  p_irq_sets_det_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask || irq_nmi) |-> det_flag);
  p_no_irq_in_rst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask || irq_nmi) |-> $past(cfg_en && !cfg_rst_mode));
  p_det_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (det_flag && !det_clr) |=> det_flag);
  p_rst_while_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_en && cfg_rst_mode && !cfg_rel_mode) && !mon_flag) |-> rst_out);
  p_off_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cfg_en) |-> (!rst_out && !irq_mask && !irq_nmi));

endmodule

// File: tb/sim_supply_mon_evt.sv
`timescale 1ns/1ps
module sim_supply_mon_evt;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_in = 1'b1, lso_tick = 1'b0;
  logic cfg_en = 1'b1, cfg_filt_en = 1'b0;
  logic [1:0] cfg_div = 2'd0, cfg_dir = 2'd0;
  logic cfg_rst_mode = 1'b0, cfg_nmi = 1'b0, cfg_rel_mode = 1'b0;
  logic [7:0] cfg_rel_cnt = 8'd0;
  logic det_clr = 1'b0;
  logic mon_flag, det_flag, irq_mask, irq_nmi, rst_out;

  int checks = 0, fails = 0;
  logic [1:0] exp_q[$];
  int tick_div = 0;

  always #2.5 clk = ~clk;

  supply_mon_evt #(.DLY_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .lso_tick(lso_tick),
    .cfg_en(cfg_en), .cfg_filt_en(cfg_filt_en), .cfg_div(cfg_div), .cfg_dir(cfg_dir),
    .cfg_rst_mode(cfg_rst_mode), .cfg_nmi(cfg_nmi), .cfg_rel_mode(cfg_rel_mode),
    .cfg_rel_cnt(cfg_rel_cnt), .det_clr(det_clr), .mon_flag(mon_flag),
    .det_flag(det_flag), .irq_mask(irq_mask), .irq_nmi(irq_nmi), .rst_out(rst_out));

  always @(negedge clk) begin
    tick_div = (tick_div + 1) % 8;
    lso_tick = (tick_div == 0);
  end

  always @(negedge clk) begin
    if (rst_n && (irq_mask || irq_nmi)) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R7 unexpected irq act=%b%b exp=none", irq_nmi, irq_mask);
      end else begin
        logic [1:0] e;
        e = exp_q.pop_front();
        if ({irq_nmi, irq_mask} != e) begin
          fails++;
          $display("FAIL R7 irq kind act=%b%b exp=%b", irq_nmi, irq_mask, e);
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] exp_irq);
    @(negedge clk);
    cmp_in = v;
    if (exp_irq != 2'b00) exp_q.push_back(exp_irq);
  endtask

  task automatic clear_det();
    @(negedge clk);
    det_clr = 1'b1;
    @(negedge clk);
    det_clr = 1'b0;
  endtask

  initial begin
    fork
      begin
        cyc(60000);
        fails++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    join_none

    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk("R4 reset mon_flag", mon_flag, 1'b1);
    chk("R5 reset det_flag", det_flag, 1'b0);
    chk("R8 reset rst_out", rst_out, 1'b0);

    // R1 timing: cmp driven at a negedge, visible after third posedge
    drive(1'b0, 2'b01);
    cyc(2);
    chk("R1 not yet at two edges", mon_flag, 1'b1);
    cyc(1);
    chk("R1 mon_flag after three edges", mon_flag, 1'b0);
    chk("R5 det set on fall", det_flag, 1'b1);
    cyc(3);
    drive(1'b1, 2'b00);   // R6 falling only: rise ignored
    cyc(5);
    chk("R4 mon_flag high", mon_flag, 1'b1);
    chk("R5 det sticky", det_flag, 1'b1);
    clear_det();
    chk("R5 det cleared", det_flag, 1'b0);

    // R6 rising only, non-maskable
    cfg_dir = 2'b01; cfg_nmi = 1'b1;
    drive(1'b0, 2'b00);
    cyc(5);
    chk("R6 fall ignored when rising selected", det_flag, 1'b0);
    drive(1'b1, 2'b10);
    cyc(5);
    chk("R6 rise counted", det_flag, 1'b1);
    clear_det();

    // R6 both directions, maskable
    cfg_dir = 2'b10; cfg_nmi = 1'b0;
    drive(1'b0, 2'b01);
    cyc(5);
    drive(1'b1, 2'b01);
    cyc(5);
    chk("R6 both det", det_flag, 1'b1);
    clear_det();

    // R5 clear and set in the same cycle: set wins
    cfg_dir = 2'b00;
    @(negedge clk); cmp_in = 1'b0; exp_q.push_back(2'b01);
    @(negedge clk);
    @(negedge clk); det_clr = 1'b1;
    @(negedge clk); det_clr = 1'b0;
    chk("R5 set wins over clear", det_flag, 1'b1);
    drive(1'b1, 2'b00);
    cyc(5);
    clear_det();

    // R2 glitch passes with filter off, rejected with filter on
    drive(1'b0, 2'b01);
    cyc(3);
    drive(1'b1, 2'b00);
    cyc(6);
    chk("R2 glitch seen unfiltered", det_flag, 1'b1);
    clear_det();
    cfg_filt_en = 1'b1; cfg_div = 2'd0;
    cyc(40);
    drive(1'b0, 2'b00);
    cyc(3);
    drive(1'b1, 2'b00);
    cyc(30);
    chk("R2 glitch rejected mon", mon_flag, 1'b1);
    chk("R2 glitch rejected det", det_flag, 1'b0);

    // R3 divider n=1 versus n=8
    drive(1'b0, 2'b01);
    cyc(5);
    chk("R2 filtered change not immediate", mon_flag, 1'b1);
    cyc(25);
    chk("R3 n=1 accepted within two samples", mon_flag, 1'b0);
    drive(1'b1, 2'b00);
    cyc(30);
    cfg_div = 2'd3;
    cyc(70);
    drive(1'b0, 2'b01);
    cyc(60);
    chk("R3 n=8 still old after 60 cycles", mon_flag, 1'b1);
    cyc(90);
    chk("R3 n=8 accepted after two samples", mon_flag, 1'b0);
    drive(1'b1, 2'b00);
    cyc(150);
    chk("R3 n=8 back high", mon_flag, 1'b1);
    cfg_filt_en = 1'b0; cfg_div = 2'd0;
    clear_det();

    // R8/R9 reset after recovery
    cfg_rst_mode = 1'b1; cfg_rel_mode = 1'b0; cfg_rel_cnt = 8'd4;
    drive(1'b0, 2'b00);
    cyc(5);
    chk("R8 rst while low", rst_out, 1'b1);
    cyc(100);
    chk("R8 rst held low", rst_out, 1'b1);
    drive(1'b1, 2'b00);
    cyc(15);
    chk("R9 rst not yet released", rst_out, 1'b1);
    cyc(45);
    chk("R9 rst released", rst_out, 1'b0);
    drive(1'b0, 2'b00);
    cyc(10);
    drive(1'b1, 2'b00);
    cyc(20);
    drive(1'b0, 2'b00);
    cyc(5);
    drive(1'b1, 2'b00);
    cyc(15);
    chk("R9 count restarted", rst_out, 1'b1);
    cyc(45);
    chk("R9 released after restart", rst_out, 1'b0);
    chk("R8 det set in reset mode", det_flag, 1'b1);
    clear_det();

    // R10 release after detection
    cfg_rel_mode = 1'b1; cfg_rel_cnt = 8'd2;
    drive(1'b0, 2'b00);
    cyc(4);
    chk("R10 rst on fall", rst_out, 1'b1);
    cyc(40);
    chk("R10 released while low", rst_out, 1'b0);
    chk("R10 level still low", mon_flag, 1'b0);
    cyc(20);
    chk("R10 no refire while low", rst_out, 1'b0);
    drive(1'b1, 2'b00);
    cyc(5);
    clear_det();

    // R11 disabled channel
    cfg_en = 1'b0; cfg_rst_mode = 1'b0;
    drive(1'b0, 2'b00);
    cyc(6);
    chk("R11 mon tracks when off", mon_flag, 1'b0);
    chk("R11 no det when off", det_flag, 1'b0);
    chk("R11 no rst when off", rst_out, 1'b0);
    drive(1'b1, 2'b00);
    cyc(6);

    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R7 missing irq act=%0d exp=0 pending", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule